// File: doc/BRIEF.md
# Quad-Rail Return-to-Neutral Channel Adapter

This block joins a clocked valid/ready word stream to a delay-insensitive channel. The channel uses four rails, of which at most one is high, plus a single acknowledge wire. On the sending side a word taken from the stream is cut into 2-bit digits. Each digit goes out as one raised rail. The sender waits for the acknowledge to rise, drops the rails to all-low, and waits for the acknowledge to fall before it raises the next rail. On the receiving side a digit counts as present when exactly one rail is high. The receiver then raises the acknowledge and keeps it high until the rails are neutral again. After the last digit it hands the rebuilt word to a valid/ready output.

Both halves sit in one top module and expose their channel wires separately. They can be looped back to each other or wired to a far-end circuit. The channel is modelled as clocked logic: each rail and the acknowledge are treated as level signals sampled on the clock edge. No timing relation between them is assumed. More than one rail high at the receiver is reported as a protocol error.

Top module: `qr_link`

## Requirements
- R1: A digit d (0 to 3) is sent by raising only rail bit d of `tx_rail`, so digit 00 uses bit 0, 01 uses bit 1, 10 uses bit 2 and 11 uses bit 3. `tx_rail` never has more than one bit high.
- R2: The sender holds its rail until `tx_ack` is seen high, then drives all rails low on the next cycle. It raises no rail while `tx_ack` is still high.
- R3: A word of WORD_W bits is sent as WORD_W/2 digits, least-significant digit first. The next digit's rail rises on the cycle after `tx_ack` is seen low.
- R4: When `rx_ack` is low and exactly one bit of `rx_rail` is high, `rx_ack` rises on the next cycle. It stays high while any rail is high, and falls on the cycle after the rails are seen all low.
- R5: Received digits are placed least-significant first. When the last digit is acknowledged, `m_data` holds the word and `m_valid` rises in that same cycle.
- R6: If two or more rails are high, `rx_err` is high on the next cycle, no acknowledge is given and no digit is stored.
- R7: While `m_valid` is high and `m_ready` is low, `m_data` stays stable and the last digit of the following word is not acknowledged.
- R8: `s_ready` is high only when the sender is idle and `tx_ack` is low.
- R9: During synchronous reset, `tx_rail`, `rx_ack`, `m_valid` and `rx_err` are low and the assembly position returns to the first digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Sender can accept a word |
| s_data | input | WORD_W | Input word |
| tx_rail | output | 4 | Outgoing one-hot rails |
| tx_ack | input | 1 | Acknowledge from the far receiver |
| rx_rail | input | 4 | Incoming one-hot rails |
| rx_ack | output | 1 | Acknowledge to the far sender |
| m_valid | output | 1 | Rebuilt word valid |
| m_ready | input | 1 | Downstream accepts the word |
| m_data | output | WORD_W | Rebuilt word |
| rx_err | output | 1 | More than one incoming rail high |

## Verification
A wrong digit counter or shift register shows up as a wrong word on `m_data` when the word completes, or as a digit sent on the wrong rail. The bench sees that within one digit handshake of the fault. A wrong handshake state shows up on the next edge: a rail held through an acknowledge, a rail raised while the acknowledge is high, or an acknowledge that never falls. Each of these stalls or corrupts the loopback within a few cycles. Error handling is checked at the ports: after an illegal rail pattern, the next complete word must come out without an extra digit in it.

// File: rtl/qr_pkg.sv
// Shared constants and the rail encode/decode helpers for the quad-rail adapter.
// Assumes a 2-bit digit maps to exactly one of four rails by its binary value.
package qr_pkg;

    localparam int RAILS = 4;

    typedef logic [RAILS-1:0] rail_t;
    typedef logic [1:0]       digit_t;

    // Raise the rail whose index equals the digit value.
    function automatic rail_t digit_to_rail(input digit_t d);
        return rail_t'(1) << d;
    endfunction

    // Return the index of the highest raised rail (only meaningful when one-hot).
    function automatic digit_t rail_to_digit(input rail_t r);
        digit_t d;
        d = 2'd0;
        for (int i = 0; i < RAILS; i++) begin
            if (r[i]) d = 2'(i);
        end
        return d;
    endfunction

endpackage

// File: rtl/qr_tx.sv
// Sender half: takes a word from a valid/ready stream and sends it digit by
// digit as single raised rails, with a return to neutral between digits.
// Assumes tx_ack is a level from the far receiver, sampled on clk.
module qr_tx
    import qr_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_data,
    output rail_t             tx_rail,
    input  logic              tx_ack
);

    localparam int DIGITS = WORD_W / 2;
    localparam int CNT_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DRIVE = 2'd1,
        TX_NEUTRAL = 2'd2
    } tx_state_t;

    tx_state_t         state_q;
    logic [WORD_W-1:0] rest_q;
    logic [CNT_W-1:0]  left_q;
    rail_t             rail_q;

    // Accept only when idle and the far side has released its acknowledge.
    always_comb begin
        s_ready = (state_q == TX_IDLE) && !tx_ack;
    end

    assign tx_rail = rail_q;

    // Digit sequencer: drive rail, wait ack high, go neutral, wait ack low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            rest_q  <= '0;
            left_q  <= '0;
            rail_q  <= '0;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    if (s_valid && s_ready) begin
                        rail_q  <= digit_to_rail(s_data[1:0]);
                        rest_q  <= s_data >> 2;
                        left_q  <= CNT_W'(DIGITS - 1);
                        state_q <= TX_DRIVE;
                    end
                end
                TX_DRIVE: begin
                    if (tx_ack) begin
                        rail_q  <= '0;
                        state_q <= TX_NEUTRAL;
                    end
                end
                TX_NEUTRAL: begin
                    if (!tx_ack) begin
                        if (left_q == '0) begin
                            state_q <= TX_IDLE;
                        end else begin
                            rail_q  <= digit_to_rail(rest_q[1:0]);
                            rest_q  <= rest_q >> 2;
                            left_q  <= left_q - 1'b1;
                            state_q <= TX_DRIVE;
                        end
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    AST_TX_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rail_q)); // R1
    AST_TX_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_q != '0 && !tx_ack) |=> (rail_q == $past(rail_q))); // R2
    AST_TX_NEUTRAL_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_q != '0 && tx_ack) |=> (rail_q == '0)); // R2
    AST_TX_NO_RAISE_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_q == '0 && tx_ack) |=> (rail_q == '0)); // R2

endmodule

// File: rtl/qr_rx.sv
// Receiver half: senses completion as exactly one raised rail, acknowledges,
// waits for neutral, and rebuilds the word least-significant digit first.
// Assumes rx_rail levels are sampled on clk. Two or more raised rails are an error.
module qr_rx
    import qr_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rail_t             rx_rail,
    output logic              rx_ack,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [WORD_W-1:0] m_data,
    output logic              rx_err
);

    localparam int DIGITS = WORD_W / 2;
    localparam int CNT_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    logic              ack_q;
    logic              err_q;
    logic              mval_q;
    logic [WORD_W-1:0] mdat_q;
    logic [CNT_W-1:0]  pos_q;
    digit_t            part_q [DIGITS];

    logic              one_hot;
    logic              multi;
    logic              neutral;
    logic              last;
    logic              out_free;
    logic              take;
    digit_t            dig;
    logic [WORD_W-1:0] word_next;

    // Completion detection and the capture condition.
    always_comb begin
        one_hot  = ($countones(rx_rail) == 1);
        multi    = ($countones(rx_rail) > 1);
        neutral  = (rx_rail == '0);
        last     = (pos_q == CNT_W'(DIGITS - 1));
        out_free = !mval_q || m_ready;
        take     = !ack_q && one_hot && (!last || out_free);
        dig      = rail_to_digit(rx_rail);
    end

    // Merge stored digits with the one arriving now into a full word.
    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_merge
            always_comb begin
                word_next[2*g +: 2] = (pos_q == CNT_W'(g)) ? dig : part_q[g];
            end
        end
    endgenerate

    // Acknowledge, digit store and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            err_q  <= 1'b0;
            mval_q <= 1'b0;
            mdat_q <= '0;
            pos_q  <= '0;
            for (int i = 0; i < DIGITS; i++) part_q[i] <= '0;
        end else begin
            err_q <= multi;
            if (mval_q && m_ready) mval_q <= 1'b0;
            if (take) begin
                ack_q <= 1'b1;
                if (last) begin
                    mdat_q <= word_next;
                    mval_q <= 1'b1;
                    pos_q  <= '0;
                end else begin
                    part_q[pos_q] <= dig;
                    pos_q         <= pos_q + 1'b1;
                end
            end else if (ack_q && neutral) begin
                ack_q <= 1'b0;
            end
        end
    end

    assign rx_ack  = ack_q;
    assign rx_err  = err_q;
    assign m_valid = mval_q;
    assign m_data  = mdat_q;

    AST_RX_NO_ACK_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_q && multi) |=> !ack_q); // R6
    AST_RX_ACK_UNTIL_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !neutral) |=> ack_q); // R4
    AST_RX_ACK_NEEDS_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(one_hot)); // R4
    AST_RX_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mval_q && !m_ready) |=> (mval_q && $stable(mdat_q))); // R7

endmodule

// File: rtl/qr_link.sv
// Top of the quad-rail adapter: a sender and a receiver with separate
// channel wires, so they can be looped back or wired to a far-end circuit.
// Assumes WORD_W is even and at least 2.
module qr_link
    import qr_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_data,
    output logic [3:0]        tx_rail,
    input  logic              tx_ack,
    input  logic [3:0]        rx_rail,
    output logic              rx_ack,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [WORD_W-1:0] m_data,
    output logic              rx_err
);

    qr_tx #(.WORD_W(WORD_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .s_data  (s_data),
        .tx_rail (tx_rail),
        .tx_ack  (tx_ack)
    );

    qr_rx #(.WORD_W(WORD_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_rail (rx_rail),
        .rx_ack  (rx_ack),
        .m_valid (m_valid),
        .m_ready (m_ready),
        .m_data  (m_data),
        .rx_err  (rx_err)
    );

endmodule

// File: tb/qr_link_test.sv
// Directed bench: one task per scenario, each checking its own results.
module qr_link_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_ready;
    logic [3:0] tx_rail;
    logic       tx_ack_drv = 1'b0;
    logic [3:0] rx_rail_drv = '0;
    logic       rx_ack;
    logic       m_valid;
    logic       m_ready = 1'b1;
    logic [7:0] m_data;
    logic       rx_err;
    logic       lb = 1'b0;
    logic       tx_ack;
    logic [3:0] rx_rail;

    int checks = 0;
    int fails  = 0;

    assign tx_ack  = lb ? rx_ack  : tx_ack_drv;
    assign rx_rail = lb ? tx_rail : rx_rail_drv;

    always #2 clk = ~clk;

    qr_link #(.WORD_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .tx_rail(tx_rail), .tx_ack(tx_ack),
        .rx_rail(rx_rail), .rx_ack(rx_ack), .m_valid(m_valid),
        .m_ready(m_ready), .m_data(m_data), .rx_err(rx_err)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk(tx_rail == 4'b0, "R9 tx_rail", 32'(tx_rail), 0);
        chk(rx_ack == 1'b0, "R9 rx_ack", 32'(rx_ack), 0);
        chk(m_valid == 1'b0, "R9 m_valid", 32'(m_valid), 0);
        chk(rx_err == 1'b0, "R9 rx_err", 32'(rx_err), 0);
        rst_n = 1'b1;
        step();
        chk(s_ready == 1'b1, "R8 idle ready", 32'(s_ready), 1);
    endtask

    // Bench acts as far receiver for word 0xE4 (digits 0,1,2,3 LSB first).
    task automatic t_tx_protocol();
        logic [7:0] w;
        w = 8'hE4;
        tx_ack_drv = 1'b1;
        #0;
        chk(s_ready == 1'b0, "R8 ready low under ack", 32'(s_ready), 0);
        tx_ack_drv = 1'b0;
        s_valid = 1'b1;
        s_data  = w;
        step();
        s_valid = 1'b0;
        chk(s_ready == 1'b0, "R8 busy", 32'(s_ready), 0);
        for (int d = 0; d < 4; d++) begin
            logic [3:0] exp_r;
            exp_r = 4'b1 << w[2*d +: 2];
            chk(tx_rail == exp_r, "R1 R3 digit rail", 32'(tx_rail), 32'(exp_r));
            step();
            chk(tx_rail == exp_r, "R2 hold without ack", 32'(tx_rail), 32'(exp_r));
            tx_ack_drv = 1'b1;
            step();
            chk(tx_rail == 4'b0, "R2 neutral after ack", 32'(tx_rail), 0);
            step();
            chk(tx_rail == 4'b0, "R2 no raise under ack", 32'(tx_rail), 0);
            tx_ack_drv = 1'b0;
            step();
        end
        chk(tx_rail == 4'b0 && s_ready, "R3 word done", 32'({s_ready, tx_rail}), 32'h10);
    endtask

    task automatic rx_digit(input logic [1:0] d);
        rx_rail_drv = 4'b1 << d;
        step();
        chk(rx_ack == 1'b1, "R4 ack rises", 32'(rx_ack), 1);
        step();
        chk(rx_ack == 1'b1, "R4 ack held", 32'(rx_ack), 1);
        rx_rail_drv = 4'b0;
        step();
        chk(rx_ack == 1'b0, "R4 ack falls", 32'(rx_ack), 0);
    endtask

    task automatic rx_word(input logic [7:0] w);
        for (int d = 0; d < 3; d++) rx_digit(w[2*d +: 2]);
        rx_rail_drv = 4'b1 << w[7:6];
        step();
        chk(m_valid == 1'b1, "R5 word valid", 32'(m_valid), 1);
        chk(m_data == w, "R5 word value", 32'(m_data), 32'(w));
        rx_rail_drv = 4'b0;
        step();
    endtask

    task automatic t_rx_basic();
        rx_word(8'h9C);
        chk(m_valid == 1'b0, "R5 valid consumed", 32'(m_valid), 0);
    endtask

    task automatic t_rx_error();
        rx_rail_drv = 4'b0011;
        step();
        chk(rx_err == 1'b1, "R6 err flagged", 32'(rx_err), 1);
        chk(rx_ack == 1'b0, "R6 no ack", 32'(rx_ack), 0);
        rx_rail_drv = 4'b1100;
        step();
        chk(rx_ack == 1'b0, "R6 still no ack", 32'(rx_ack), 0);
        rx_rail_drv = 4'b0;
        step();
        chk(rx_err == 1'b0, "R6 err clears", 32'(rx_err), 0);
        rx_word(8'h36);
    endtask

    task automatic t_backpressure();
        m_ready = 1'b0;
        rx_word(8'h5A);
        for (int d = 0; d < 3; d++) rx_digit(2'(d));
        rx_rail_drv = 4'b1000;
        step();
        chk(rx_ack == 1'b0, "R7 last digit held off", 32'(rx_ack), 0);
        step();
        chk(rx_ack == 1'b0 && m_data == 8'h5A, "R7 data stable",
            32'({rx_ack, m_data}), 32'h5A);
        m_ready = 1'b1;
        step();
        chk(rx_ack == 1'b1, "R7 ack after release", 32'(rx_ack), 1);
        chk(m_valid && m_data == 8'hE4, "R7 next word", 32'({m_valid, m_data}), 32'h1E4);
        rx_rail_drv = 4'b0;
        step();
        step();
    endtask

    task automatic t_loopback(input logic [7:0] w);
        bit seen;
        lb = 1'b1;
        s_valid = 1'b1;
        s_data  = w;
        while (!s_ready) step();
        step();
        s_valid = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            step();
            if (m_valid) begin
                seen = 1'b1;
                chk(m_data == w, "R3 R5 loopback word", 32'(m_data), 32'(w));
            end
        end
        if (!seen) chk(1'b0, "R5 loopback timeout", 0, 32'(w));
        repeat (6) step();
        lb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_tx_protocol();
        t_rx_basic();
        t_rx_error();
        t_backpressure();
        t_loopback(8'h00);
        t_loopback(8'hFF);
        t_loopback(8'hA5);
        t_loopback(8'h1B);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule